// File: doc/BRIEF.md
# Priority-Resolved Multifunction Shift Register

This block is a small storage register with three independent request lines: one to capture a parallel word, one to shift toward the least significant bit and one to shift toward the most significant bit. Each shift direction has its own serial input bit. A fixed priority turns the three requests into one 2-bit operation code: capture wins over a right shift, and a right shift wins over a left shift. A 4-to-1 selector in front of every storage bit uses that code to pick the bit's next value. When no request is raised, the register keeps its contents.

The operation code is also driven out on a port, so surrounding logic or a checker can see which operation the register will perform at the next rising edge. The width is a parameter with a default of 4. A synchronous, active-high reset clears the contents.

Top module: `msr_reg`

## Requirements
- R1: When `rst` is 1 at a rising clock edge, `data_q` becomes all zeros after that edge, whatever the request lines and data inputs are.
- R2: When `rst` is 0 and `ld_req` is 1, `data_q` takes the value of `par_in` at the edge, whatever the shift requests are, and `op_sel` is 2'b01.
- R3: When `ld_req` is 0 and `shr_req` is 1, whatever `shl_req` is, the edge gives `data_q` = {`shr_ser`, previous `data_q[WIDTH-1:1]`}: every bit moves one place toward bit 0 and `shr_ser` enters the top bit. `op_sel` is 2'b10.
- R4: When `ld_req` and `shr_req` are 0 and `shl_req` is 1, the edge gives `data_q` = {previous `data_q[WIDTH-2:0]`, `shl_ser`}: every bit moves one place toward the top bit and `shl_ser` enters bit 0. `op_sel` is 2'b11.
- R5: When all three request lines are 0, `data_q` keeps its value across the edge, whatever `par_in` and the serial inputs are, and `op_sel` is 2'b00.
- R6: `op_sel` is combinational in the current request lines. It shows the resolved code in the same cycle as the requests, with no register delay, and it does so while `rst` is asserted as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every update happens on its rising edge |
| rst | input | 1 | Synchronous active-high clear |
| ld_req | input | 1 | Parallel capture request (highest priority) |
| shr_req | input | 1 | Shift toward bit 0 request |
| shl_req | input | 1 | Shift toward the top bit request (lowest priority) |
| par_in | input | WIDTH | Parallel data word |
| shr_ser | input | 1 | Bit that enters the top position on a right shift |
| shl_ser | input | 1 | Bit that enters bit 0 on a left shift |
| data_q | output | WIDTH | Register contents |
| op_sel | output | 2 | Resolved code: 00 hold, 01 load, 10 right, 11 left |

## Verification
The bench starts from every one of the sixteen register values and applies each of the eight request combinations, with all four serial-input pairs and a parallel word that differs from the current contents. This covers the overlap cases. If load did not dominate, a shift result would appear where `par_in` belongs. If the right/left tie were resolved the wrong way, data would move in the wrong direction. If the serial inputs were swapped or the end bits miswired, only the patterns with differing serial bits would show the error, and the sweep includes those. Reset is applied with every request line raised, to catch a clear that loses to a load or a shift. The bench also checks `op_sel` before each edge, which catches a code that is registered instead of combinational.

// File: rtl/msr_pkg.sv
package msr_pkg;
    typedef enum logic [1:0] {
        OP_HOLD  = 2'b00,
        OP_LOAD  = 2'b01,
        OP_RIGHT = 2'b10,
        OP_LEFT  = 2'b11
    } msr_op_e;
endpackage

// File: rtl/msr_sel_encode.sv
module msr_sel_encode
    import msr_pkg::*;
(
    input  logic    ld_req,
    input  logic    shr_req,
    input  logic    shl_req,
    output msr_op_e op
);
    logic s1, s0;
    always_comb begin
        // fixed priority: load, then right, then left
        s1 = ~ld_req & (shr_req | shl_req);
        s0 = ld_req | (~ld_req & ~shr_req & shl_req);
        op = msr_op_e'({s1, s0});
    end
endmodule

// File: rtl/msr_bit_mux.sv
module msr_bit_mux
    import msr_pkg::*;
(
    input  msr_op_e op,
    input  logic    cur,
    input  logic    par,
    input  logic    from_above,
    input  logic    from_below,
    output logic    nxt
);
    always_comb begin
        unique case (op)
            OP_HOLD:  nxt = cur;
            OP_LOAD:  nxt = par;
            OP_RIGHT: nxt = from_above;
            OP_LEFT:  nxt = from_below;
            default:  nxt = cur;
        endcase
    end
endmodule

// File: rtl/msr_reg.sv
module msr_reg
    import msr_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_req,
    input  logic             shr_req,
    input  logic             shl_req,
    input  logic [WIDTH-1:0] par_in,
    input  logic             shr_ser,
    input  logic             shl_ser,
    output logic [WIDTH-1:0] data_q,
    output logic [1:0]       op_sel
);
    localparam int TOP = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] data;
    } msr_state_t;

    msr_state_t       state_d, state_q;
    msr_op_e          op;
    logic [WIDTH-1:0] bit_nxt;

    msr_sel_encode u_enc (
        .ld_req  (ld_req),
        .shr_req (shr_req),
        .shl_req (shl_req),
        .op      (op)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic above, below;
        if (i == TOP) begin : g_top
            assign above = shr_ser;
        end else begin : g_mid_a
            assign above = state_q.data[i+1];
        end
        if (i == 0) begin : g_bot
            assign below = shl_ser;
        end else begin : g_mid_b
            assign below = state_q.data[i-1];
        end
        msr_bit_mux u_mux (
            .op         (op),
            .cur        (state_q.data[i]),
            .par        (par_in[i]),
            .from_above (above),
            .from_below (below),
            .nxt        (bit_nxt[i])
        );
    end

    always_comb begin
        state_d      = state_q;
        state_d.data = bit_nxt;
        if (rst) begin
            state_d.data = '0;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign data_q = state_q.data;
    assign op_sel = op;
endmodule

// File: rtl/msr_reg_chk.sv
module msr_reg_chk #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             ld_req,
    input logic             shr_req,
    input logic             shl_req,
    input logic [WIDTH-1:0] par_in,
    input logic             shr_ser,
    input logic             shl_ser,
    input logic [WIDTH-1:0] data_q,
    input logic [1:0]       op_sel
);
    // R1
    clear_on_reset_chk: assert property (@(posedge clk)
        rst |=> data_q == '0);

    // R2
    load_wins_chk: assert property (@(posedge clk) disable iff (rst)
        ld_req |=> data_q == $past(par_in));

    // R3
    right_shift_chk: assert property (@(posedge clk) disable iff (rst)
        (!ld_req && shr_req) |=> data_q == {$past(shr_ser), $past(data_q[WIDTH-1:1])});

    // R4
    left_shift_chk: assert property (@(posedge clk) disable iff (rst)
        (!ld_req && !shr_req && shl_req) |=> data_q == {$past(data_q[WIDTH-2:0]), $past(shl_ser)});

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!ld_req && !shr_req && !shl_req) |=> $stable(data_q));

    // R6
    code_in_reset_chk: assert property (@(posedge clk)
        (rst && ld_req) |-> op_sel == 2'b01);

    // R6
    code_right_chk: assert property (@(posedge clk)
        (!ld_req && shr_req) |-> op_sel == 2'b10);
endmodule

bind msr_reg msr_reg_chk #(.WIDTH(WIDTH)) u_msr_chk (
    .clk     (clk),
    .rst     (rst),
    .ld_req  (ld_req),
    .shr_req (shr_req),
    .shl_req (shl_req),
    .par_in  (par_in),
    .shr_ser (shr_ser),
    .shl_ser (shl_ser),
    .data_q  (data_q),
    .op_sel  (op_sel)
);

// File: tb/msr_reg_bench.sv
`timescale 1ns/1ps
module msr_reg_bench;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst;
    logic         ld_req, shr_req, shl_req;
    logic [W-1:0] par_in;
    logic         shr_ser, shl_ser;
    logic [W-1:0] data_q;
    logic [1:0]   op_sel;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    msr_reg #(.WIDTH(W)) u_msr_reg (
        .clk     (clk),
        .rst     (rst),
        .ld_req  (ld_req),
        .shr_req (shr_req),
        .shl_req (shl_req),
        .par_in  (par_in),
        .shr_ser (shr_ser),
        .shl_ser (shl_ser),
        .data_q  (data_q),
        .op_sel  (op_sel)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(input bit r, input bit l, input bit sr, input bit sl,
                         input logic [W-1:0] p, input bit rs, input bit ls);
        rst = r; ld_req = l; shr_req = sr; shl_req = sl;
        par_in = p; shr_ser = rs; shl_ser = ls;
    endtask

    initial begin
        drive(1, 1, 1, 1, 4'hA, 1, 1);
        @(negedge clk);
        // R6: code visible combinationally even during reset
        #1 check("R6", op_sel, 1);
        @(posedge clk); @(negedge clk);
        // R1: reset beats every request line
        check("R1", data_q, 0);

        for (int start = 0; start < 16; start++) begin
            for (int ctl = 0; ctl < 8; ctl++) begin
                for (int ser = 0; ser < 4; ser++) begin
                    logic [W-1:0] p;
                    int exp_q, exp_op;
                    bit l, sr, sl, rs, ls;
                    string tag;
                    drive(0, 1, 0, 0, W'(start), 0, 0);
                    @(posedge clk); @(negedge clk);
                    l = ctl[2]; sr = ctl[1]; sl = ctl[0];
                    rs = ser[1]; ls = ser[0];
                    p = ~W'(start);
                    if (l) begin
                        exp_q = int'(p); exp_op = 1; tag = "R2";
                    end else if (sr) begin
                        exp_q = (start >> 1) | (int'(rs) << 3); exp_op = 2; tag = "R3";
                    end else if (sl) begin
                        exp_q = ((start << 1) & 15) | int'(ls); exp_op = 3; tag = "R4";
                    end else begin
                        exp_q = start; exp_op = 0; tag = "R5";
                    end
                    drive(0, l, sr, sl, p, rs, ls);
                    // R6: code present before the edge
                    #1 check("R6", op_sel, exp_op);
                    @(posedge clk); @(negedge clk);
                    check(tag, data_q, exp_q);
                end
            end
        end

        drive(0, 1, 0, 0, 4'hF, 0, 0);
        @(posedge clk); @(negedge clk);
        drive(1, 0, 1, 0, 4'h5, 1, 1);
        @(posedge clk); @(negedge clk);
        // R1: reset overrides a pending right shift
        check("R1", data_q, 0);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                errors++;
                $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            end
        join_any
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule